// File: doc/BRIEF.md
# Pipelined Synchronous Burst SRAM

This block is a synthesizable behavioural model of a small pipelined synchronous SRAM that carries its own burst addressing. Commands are sampled on the rising clock edge. Either of two start strobes loads a fresh address. The processor-side strobe always begins a read. The controller-side strobe begins a read or a write, as the write controls select. Later cycles of the burst either step a 2-bit counter on the two low address bits or hold it in place. The counter steps in linear or in interleaved order, and the order is latched when the burst starts.

Read data passes through a command register and then an output register. A drive-enable output tells the surrounding pad logic when the data bus is to be driven. An asynchronous output-enable input gates that drive-enable. A mode pin sets how fast the drive-enable drops after a non-read command:

- In single-cycle mode it drops in the same stage in which the command is registered. A read that is followed at once by a non-read therefore becomes a dummy cycle.
- In dual-cycle mode it drops one cycle later.

A sleep input freezes the block two cycles after it is raised. After sleep is released, a recovery window of a configurable length follows. A write issued inside that window is dropped and flagged.

Top module: `pbs_sram`

## Requirements
- R1: With `ce_n_i` low, a low level on either start strobe loads `addr_i` as the new burst base, and that access uses `addr_i`. A start on `cpu_strb_n_i` is always a read, even when the write controls are asserted. A start on `ctl_strb_n_i` alone writes when the write controls request a write.
- R2: When a burst starts with `order_il_i` = 0, access n of the burst (n = 0 for the start) uses low address bits (start + n) mod 4, and the upper address bits stay fixed. The fifth access wraps back to the start value. The order is taken from the start cycle only.
- R3: When a burst starts with `order_il_i` = 1, access n uses low address bits start XOR (n mod 4).
- R4: In a burst cycle with no strobe and `adv_n_i` high, the access repeats the previous burst address and the counter does not step.
- R5: `gw_n_i` low writes all four byte lanes. Otherwise `bw_n_i` low writes exactly the lanes whose `lane_sel_n_i` bit is low; lane i is `wdata_i[8i+7:8i]`. When neither requests a lane, the access is a read.
- R6: A read registered at edge k presents the word on `dq_o` after edge k+1. After reset, `dq_o` is 0 and `dq_oe_o` is 0.
- R7: `oe_n_i` high forces `dq_oe_o` low without waiting for a clock. Returning it low restores the drive.
- R8: With `sgl_dsel_i` = 1, a non-read command (deselect, write or idle) at edge e leaves `dq_oe_o` low after edge e. A read at edge k drives after edge k+1 only when edge k+1 also registers a read.
- R9: With `sgl_dsel_i` = 0, a read at edge k drives after edge k+1 regardless of the next command. After a non-read at edge e, `dq_oe_o` is low after edge e+1.
- R10: `ce_n_i` high together with a start strobe deselects and ends the burst. Advance cycles that follow perform no access and do not drive.
- R11: When `sleep_i` is sampled high at two consecutive edges, `dq_oe_o` is low after the second edge. Commands at later edges are ignored until release, and the memory keeps its contents.
- R12: A write at any of the first RECOVER_CYC edges after sleep ends is not performed, and `wr_err_o` is high for the following cycle. Reads are served normally in that window. Sleep ends at the second edge that samples `sleep_i` low. Writes at later edges behave normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_i | input | ADDR_W | Word address loaded at burst start |
| ce_n_i | input | 1 | Chip enable, active low |
| cpu_strb_n_i | input | 1 | Processor-side start strobe, active low, read only |
| ctl_strb_n_i | input | 1 | Controller-side start strobe, active low |
| adv_n_i | input | 1 | Burst advance, active low |
| order_il_i | input | 1 | Burst order: 0 linear, 1 interleaved |
| gw_n_i | input | 1 | Write all lanes, active low |
| bw_n_i | input | 1 | Lane-selective write enable, active low |
| lane_sel_n_i | input | LANES | Per-lane select, active low |
| wdata_i | input | LANES*LANE_W | Write data |
| oe_n_i | input | 1 | Asynchronous output enable, active low |
| sgl_dsel_i | input | 1 | 1 single-cycle turn-off, 0 dual-cycle turn-off |
| sleep_i | input | 1 | Sleep request, active high |
| dq_o | output | LANES*LANE_W | Registered read data |
| dq_oe_o | output | 1 | Drive enable for the data bus |
| wr_err_o | output | 1 | Pulse for a write dropped during recovery |

## Verification
Several properties are checked on every clock:

- In single-cycle mode, a deselect is followed by a released bus one cycle later.
- In dual-cycle mode, the bus is released two cycles after a deselect.
- Two consecutive high samples of `sleep_i` always leave the bus released.
- A recovery error only ever follows a cycle that carried a write request.

The bench's scenarios are the only place where the following are shown:

- the read data values and the lane merging;
- the burst address sequences and their wrap;
- the dummy-read cycles of single-cycle mode;
- retention of memory contents across sleep;
- the dropping of writes inside the recovery window.

// File: rtl/pbs_pkg.sv
package pbs_pkg;
  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } op_e;

  function automatic logic [1:0] burst_low(input logic [1:0] start,
                                           input logic [1:0] cnt,
                                           input logic       il);
    burst_low = il ? (start ^ cnt) : (start + cnt);
  endfunction
endpackage

// File: rtl/pbs_burst.sv
module pbs_burst
  import pbs_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int LANES  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hold_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              ce_n_i,
  input  logic              cpu_n_i,
  input  logic              ctl_n_i,
  input  logic              adv_n_i,
  input  logic              order_il_i,
  input  logic              gw_n_i,
  input  logic              bw_n_i,
  input  logic [LANES-1:0]  lane_sel_n_i,
  output op_e               op_o,
  output logic [ADDR_W-1:0] acc_addr_o,
  output logic [LANES-1:0]  lanes_o
);
  logic [ADDR_W-1:0] base_q, base_n;
  logic [1:0]        cnt_q, cnt_n, cnt_sel;
  logic              il_q, il_n, act_q, act_n;
  logic              strobe, wr_req;

  assign strobe  = !cpu_n_i || !ctl_n_i;
  assign wr_req  = !gw_n_i || (!bw_n_i && (|(~lane_sel_n_i)));
  assign lanes_o = !gw_n_i ? {LANES{1'b1}} : (!bw_n_i ? ~lane_sel_n_i : {LANES{1'b0}});

  always_comb begin
    base_n     = base_q;
    cnt_n      = cnt_q;
    il_n       = il_q;
    act_n      = act_q;
    cnt_sel    = cnt_q;
    op_o       = OP_NONE;
    acc_addr_o = base_q;
    if (!hold_i) begin
      if (strobe && ce_n_i) begin
        act_n = 1'b0;
      end else if (strobe) begin
        base_n     = addr_i;
        cnt_n      = 2'd0;
        il_n       = order_il_i;
        act_n      = 1'b1;
        acc_addr_o = addr_i;
        op_o       = (!cpu_n_i || !wr_req) ? OP_READ : OP_WRITE;
      end else if (act_q) begin
        cnt_sel    = adv_n_i ? cnt_q : (cnt_q + 2'd1);
        cnt_n      = cnt_sel;
        acc_addr_o = {base_q[ADDR_W-1:2], burst_low(base_q[1:0], cnt_sel, il_q)};
        op_o       = wr_req ? OP_WRITE : OP_READ;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      cnt_q  <= 2'd0;
      il_q   <= 1'b0;
      act_q  <= 1'b0;
    end else begin
      base_q <= base_n;
      cnt_q  <= cnt_n;
      il_q   <= il_n;
      act_q  <= act_n;
    end
  end
endmodule

// File: rtl/pbs_sleep.sv
module pbs_sleep #(
  parameter int RECOVER_CYC = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sleep_i,
  input  logic wr_req_i,
  output logic asleep_o,
  output logic wr_ok_o,
  output logic wr_err_o
);
  localparam int RC_W = $clog2(RECOVER_CYC + 1);
  localparam logic [RC_W-1:0] RC_LOAD = RC_W'(RECOVER_CYC);

  logic            sl1_q, sl2_q, err_q, err_n;
  logic [RC_W-1:0] rc_q, rc_n;
  logic            recovering;

  assign recovering = (rc_q != '0);
  assign asleep_o   = sl2_q;
  assign wr_ok_o    = !recovering;
  assign wr_err_o   = err_q;

  always_comb begin
    rc_n = rc_q;
    if (sl2_q && !sl1_q) begin
      rc_n = RC_LOAD;
    end else if (recovering) begin
      rc_n = rc_q - 1'b1;
    end
    err_n = wr_req_i && recovering;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sl1_q <= 1'b0;
      sl2_q <= 1'b0;
      rc_q  <= '0;
      err_q <= 1'b0;
    end else begin
      sl1_q <= sleep_i;
      sl2_q <= sl1_q;
      rc_q  <= rc_n;
      err_q <= err_n;
    end
  end
endmodule

// File: rtl/pbs_array.sv
module pbs_array #(
  parameter int ADDR_W = 5,
  parameter int LANES  = 4,
  parameter int LANE_W = 8
) (
  input  logic                    clk,
  input  logic                    we_i,
  input  logic [LANES-1:0]        lanes_i,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic [LANES*LANE_W-1:0] wdata_i,
  output logic [LANES*LANE_W-1:0] rdata_o
);
  localparam int DEPTH = 2 ** ADDR_W;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] bank [DEPTH];
    always_ff @(posedge clk) begin
      if (we_i && lanes_i[g]) begin
        bank[addr_i] <= wdata_i[g*LANE_W +: LANE_W];
      end
    end
    assign rdata_o[g*LANE_W +: LANE_W] = bank[addr_i];
  end
endmodule

// File: rtl/pbs_outpipe.sv
module pbs_outpipe
  import pbs_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int LANES  = 4,
  parameter int LANE_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  op_e                     op_i,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic [LANES-1:0]        lanes_i,
  input  logic [LANES*LANE_W-1:0] wdata_i,
  input  logic                    sgl_dsel_i,
  input  logic [LANES*LANE_W-1:0] mem_rdata_i,
  output logic                    mem_we_o,
  output logic [LANES-1:0]        mem_lanes_o,
  output logic [ADDR_W-1:0]       mem_addr_o,
  output logic [LANES*LANE_W-1:0] mem_wdata_o,
  output logic [LANES*LANE_W-1:0] dout_o,
  output logic                    drive_o
);
  localparam int DATA_W = LANES * LANE_W;

  op_e               s1_op_q;
  logic [ADDR_W-1:0] s1_addr_q;
  logic [LANES-1:0]  s1_lanes_q;
  logic [DATA_W-1:0] s1_wdata_q, dout_q, dout_n;
  logic              drive_q, drive_n, s1_rd, addr_en, wd_en;

  assign s1_rd   = (s1_op_q == OP_READ);
  assign addr_en = (op_i != OP_NONE);
  assign wd_en   = (op_i == OP_WRITE);

  always_comb begin
    dout_n  = s1_rd ? mem_rdata_i : dout_q;
    drive_n = sgl_dsel_i ? (s1_rd && (op_i == OP_READ)) : s1_rd;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_op_q    <= OP_NONE;
      s1_addr_q  <= '0;
      s1_lanes_q <= '0;
      s1_wdata_q <= '0;
      dout_q     <= '0;
      drive_q    <= 1'b0;
    end else begin
      s1_op_q <= op_i;
      if (addr_en) begin
        s1_addr_q <= addr_i;
      end
      if (wd_en) begin
        s1_lanes_q <= lanes_i;
        s1_wdata_q <= wdata_i;
      end
      dout_q  <= dout_n;
      drive_q <= drive_n;
    end
  end

  assign mem_we_o    = (s1_op_q == OP_WRITE);
  assign mem_lanes_o = s1_lanes_q;
  assign mem_addr_o  = s1_addr_q;
  assign mem_wdata_o = s1_wdata_q;
  assign dout_o      = dout_q;
  assign drive_o     = drive_q;
endmodule

// File: rtl/pbs_sram.sv
module pbs_sram
  import pbs_pkg::*;
#(
  parameter int ADDR_W      = 5,
  parameter int LANES       = 4,
  parameter int LANE_W      = 8,
  parameter int RECOVER_CYC = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic                    ce_n_i,
  input  logic                    cpu_strb_n_i,
  input  logic                    ctl_strb_n_i,
  input  logic                    adv_n_i,
  input  logic                    order_il_i,
  input  logic                    gw_n_i,
  input  logic                    bw_n_i,
  input  logic [LANES-1:0]        lane_sel_n_i,
  input  logic [LANES*LANE_W-1:0] wdata_i,
  input  logic                    oe_n_i,
  input  logic                    sgl_dsel_i,
  input  logic                    sleep_i,
  output logic [LANES*LANE_W-1:0] dq_o,
  output logic                    dq_oe_o,
  output logic                    wr_err_o
);
  localparam int DATA_W = LANES * LANE_W;

  logic [1:0]        rs_q;
  logic              rst_sn;
  logic              asleep, wr_ok, drive;
  op_e               b_op, eff_op;
  logic [ADDR_W-1:0] b_addr, m_addr;
  logic [LANES-1:0]  b_lanes, m_lanes;
  logic [DATA_W-1:0] m_wdata, m_rdata, dout;
  logic              m_we;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_q <= 2'b00;
    end else begin
      rs_q <= {rs_q[0], 1'b1};
    end
  end
  assign rst_sn = rs_q[1];

  pbs_burst #(.ADDR_W(ADDR_W), .LANES(LANES)) u_burst (
    .clk(clk), .rst_n(rst_sn), .hold_i(asleep), .addr_i(addr_i),
    .ce_n_i(ce_n_i), .cpu_n_i(cpu_strb_n_i), .ctl_n_i(ctl_strb_n_i),
    .adv_n_i(adv_n_i), .order_il_i(order_il_i), .gw_n_i(gw_n_i),
    .bw_n_i(bw_n_i), .lane_sel_n_i(lane_sel_n_i),
    .op_o(b_op), .acc_addr_o(b_addr), .lanes_o(b_lanes)
  );

  pbs_sleep #(.RECOVER_CYC(RECOVER_CYC)) u_sleep (
    .clk(clk), .rst_n(rst_sn), .sleep_i(sleep_i),
    .wr_req_i(b_op == OP_WRITE), .asleep_o(asleep),
    .wr_ok_o(wr_ok), .wr_err_o(wr_err_o)
  );

  assign eff_op = ((b_op == OP_WRITE) && !wr_ok) ? OP_NONE : b_op;

  pbs_outpipe #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_pipe (
    .clk(clk), .rst_n(rst_sn), .op_i(eff_op), .addr_i(b_addr),
    .lanes_i(b_lanes), .wdata_i(wdata_i), .sgl_dsel_i(sgl_dsel_i),
    .mem_rdata_i(m_rdata), .mem_we_o(m_we), .mem_lanes_o(m_lanes),
    .mem_addr_o(m_addr), .mem_wdata_o(m_wdata), .dout_o(dout), .drive_o(drive)
  );

  pbs_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
    .clk(clk), .we_i(m_we), .lanes_i(m_lanes), .addr_i(m_addr),
    .wdata_i(m_wdata), .rdata_o(m_rdata)
  );

  assign dq_o    = dout;
  assign dq_oe_o = drive && !oe_n_i && !asleep;
endmodule

// File: rtl/pbs_chk.sv
module pbs_chk (
  input logic clk,
  input logic rst_n,
  input logic sleep_i,
  input logic cpu_n,
  input logic ctl_n,
  input logic ce_n,
  input logic sgl_dsel,
  input logic gw_n,
  input logic bw_n,
  input logic dq_oe,
  input logic wr_err
);
  logic dsel;
  assign dsel = ce_n && (!cpu_n || !ctl_n);

  // R8
  scd_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sgl_dsel && dsel) |=> !dq_oe);

  // R9
  dcd_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sgl_dsel && dsel) ##1 !sgl_dsel |=> !dq_oe);

  // R11
  sleep_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_i ##1 sleep_i |=> !dq_oe);

  // R12
  err_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_err |-> $past(!gw_n || !bw_n));
endmodule

bind pbs_sram pbs_chk u_chk (
  .clk(clk), .rst_n(rst_sn), .sleep_i(sleep_i), .cpu_n(cpu_strb_n_i),
  .ctl_n(ctl_strb_n_i), .ce_n(ce_n_i), .sgl_dsel(sgl_dsel_i),
  .gw_n(gw_n_i), .bw_n(bw_n_i), .dq_oe(dq_oe_o), .wr_err(wr_err_o)
);

// File: tb/pbs_sram_test.sv
module pbs_sram_test;
  logic        clk, rst_n;
  logic [4:0]  addr;
  logic        ce_n, cpu_n, ctl_n, adv_n, order_il, gw_n, bw_n;
  logic [3:0]  lsel_n;
  logic [31:0] wdata;
  logic        oe_n, sgl, sleep;
  logic [31:0] dq_o;
  logic        dq_oe_o, wr_err_o;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [31:0] model [32];
  bit pend_v = 0;
  int pend_a = 0;
  string pend_tag = "";

  pbs_sram uut (
    .clk(clk), .rst_n(rst_n), .addr_i(addr), .ce_n_i(ce_n),
    .cpu_strb_n_i(cpu_n), .ctl_strb_n_i(ctl_n), .adv_n_i(adv_n),
    .order_il_i(order_il), .gw_n_i(gw_n), .bw_n_i(bw_n),
    .lane_sel_n_i(lsel_n), .wdata_i(wdata), .oe_n_i(oe_n),
    .sgl_dsel_i(sgl), .sleep_i(sleep), .dq_o(dq_o), .dq_oe_o(dq_oe_o),
    .wr_err_o(wr_err_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [31:0] pat(input int a);
    pat = (32'h1003_0507 * (a + 1)) ^ 32'h5A5A_3C3C;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic go_idle();
    cpu_n = 1; ctl_n = 1; adv_n = 1; gw_n = 1; bw_n = 1; lsel_n = 4'hF; ce_n = 0;
  endtask

  task automatic rd_cmd(input int a, input bit by_cpu);
    go_idle();
    addr = 5'(a);
    if (by_cpu) cpu_n = 0; else ctl_n = 0;
  endtask

  task automatic wr_cmd(input int a, input logic [31:0] d, input logic [3:0] m, input bit glob);
    go_idle();
    ctl_n = 0; addr = 5'(a); wdata = d;
    if (glob) gw_n = 0;
    else begin bw_n = 0; lsel_n = ~m; end
  endtask

  task automatic mdl_wr(input int a, input logic [31:0] d, input logic [3:0] m);
    for (int i = 0; i < 4; i++)
      if (m[i]) model[a][8*i +: 8] = d[8*i +: 8];
  endtask

  task automatic dsel_cmd();
    go_idle(); ce_n = 1; ctl_n = 0;
  endtask

  // one clock; check the read registered two edges back, then queue the new one
  task automatic cyc(input bit nv, input int na, input string ntag);
    tick();
    if (pend_v) begin
      chk({pend_tag, " data"}, dq_o, model[pend_a]);
      chk({pend_tag, " drive"}, {31'd0, dq_oe_o}, 32'd1);
    end
    pend_v = nv; pend_a = na; pend_tag = ntag;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 0; go_idle(); addr = 0; wdata = 0; oe_n = 0; sgl = 0; sleep = 0; order_il = 0;
    repeat (3) tick();
    rst_n = 1;
    repeat (3) tick();
    // R6 reset state
    chk("R6 reset dq", dq_o, 32'd0);
    chk("R6 reset drive", {31'd0, dq_oe_o}, 32'd0);
    chk("R12 reset err", {31'd0, wr_err_o}, 32'd0);

    // R5 global fill, then R1/R6 pipelined reads with both strobes
    for (int a = 0; a < 32; a++) begin
      wr_cmd(a, pat(a), 4'h0, 1); mdl_wr(a, pat(a), 4'hF);
      cyc(0, 0, "");
    end
    for (int a = 0; a < 32; a++) begin
      rd_cmd(a, a[0]);
      cyc(1, a, "R1 R6 readback");
    end
    go_idle(); cyc(0, 0, "");

    // R5 lane sweep, R1 processor strobe never writes
    for (int m = 0; m < 16; m++) begin
      wr_cmd(m, 32'h0, 4'h0, 1); mdl_wr(m, 32'h0, 4'hF); cyc(0, 0, "");
      wr_cmd(m, 32'hA1B2_C3D4 ^ (m * 32'h0101_0101), 4'(m), 0);
      mdl_wr(m, 32'hA1B2_C3D4 ^ (m * 32'h0101_0101), 4'(m));
      cyc(0, 0, "");
      go_idle(); cpu_n = 0; gw_n = 0; addr = 5'(m); wdata = 32'hFFFF_FFFF;
      cyc(1, m, "R1 cpu strobe ignores write");
    end
    go_idle(); cyc(0, 0, "");
    go_idle(); ctl_n = 0; gw_n = 0; bw_n = 0; lsel_n = 4'hF; addr = 5'd20; wdata = 32'h1357_9BDF;
    mdl_wr(20, 32'h1357_9BDF, 4'hF); cyc(0, 0, "");
    go_idle(); bw_n = 1; ctl_n = 0; lsel_n = 4'h0; addr = 5'd21; wdata = 32'h0;
    cyc(1, 21, "R5 no enable is read");
    for (int m = 0; m < 16; m++) begin
      rd_cmd(m, 0); cyc(1, m, "R5 lanes");
    end
    rd_cmd(20, 0); cyc(1, 20, "R5 global overrides");
    go_idle(); cyc(0, 0, "");

    // R2/R3 burst orders, R4 suspend, R10 deselect
    for (int il = 0; il < 2; il++) begin
      for (int s = 0; s < 4; s++) begin
        int hi, lo;
        string tg;
        tg = il ? "R3 interleaved" : "R2 linear";
        hi = 4 + 2 * il;
        order_il = il[0];
        rd_cmd(hi * 4 + s, 0);
        cyc(1, hi * 4 + s, tg);
        order_il = ~il[0];
        for (int i = 1; i <= 5; i++) begin
          lo = il ? (s ^ (i % 4)) : ((s + i) % 4);
          go_idle(); adv_n = 0;
          cyc(1, hi * 4 + lo, tg);
          if (i == 4) begin
            go_idle();
            cyc(1, hi * 4 + lo, "R4 suspend");
          end
        end
        dsel_cmd(); cyc(0, 0, "");
        go_idle(); adv_n = 0; cyc(0, 0, "");
        go_idle(); adv_n = 0; cyc(0, 0, "");
        chk("R10 no drive after deselect", {31'd0, dq_oe_o}, 32'd0);
      end
    end
    order_il = 0;

    // R9 dual-cycle turn-off
    rd_cmd(7, 0); tick();
    dsel_cmd(); tick();
    chk("R9 read drives", {31'd0, dq_oe_o}, 32'd1);
    chk("R9 read data", dq_o, model[7]);
    go_idle(); tick();
    chk("R9 off one later", {31'd0, dq_oe_o}, 32'd0);

    // R7 asynchronous output enable
    rd_cmd(9, 0); tick();
    go_idle(); tick();
    chk("R7 base drive", {31'd0, dq_oe_o}, 32'd1);
    #1 oe_n = 1; #1;
    chk("R7 oe high", {31'd0, dq_oe_o}, 32'd0);
    oe_n = 0; #1;
    chk("R7 oe low", {31'd0, dq_oe_o}, 32'd1);
    dsel_cmd(); tick(); go_idle(); tick();

    // R8 single-cycle turn-off
    sgl = 1; tick();
    rd_cmd(10, 0); tick();
    rd_cmd(11, 0); tick();
    chk("R8 read-read drives", {31'd0, dq_oe_o}, 32'd1);
    chk("R8 read-read data", dq_o, model[10]);
    rd_cmd(12, 0); tick();
    chk("R8 stream data", dq_o, model[11]);
    dsel_cmd(); tick();
    chk("R8 dummy read off", {31'd0, dq_oe_o}, 32'd0);
    go_idle(); tick();
    chk("R8 stays off", {31'd0, dq_oe_o}, 32'd0);
    rd_cmd(13, 0); tick();
    dsel_cmd(); tick();
    chk("R8 single read dummy", {31'd0, dq_oe_o}, 32'd0);
    rd_cmd(14, 0); tick();
    rd_cmd(15, 0); tick();
    chk("R8 before write", {31'd0, dq_oe_o}, 32'd1);
    wr_cmd(15, model[15], 4'h0, 1); tick();
    chk("R8 write turns off", {31'd0, dq_oe_o}, 32'd0);
    go_idle(); tick();
    sgl = 0; tick();

    // R11 sleep entry and retention, R12 recovery window
    rd_cmd(3, 0); tick();
    sleep = 1; rd_cmd(3, 0); tick();
    chk("R11 before sleep drive", {31'd0, dq_oe_o}, 32'd1);
    chk("R11 before sleep data", dq_o, model[3]);
    rd_cmd(3, 0); tick();
    chk("R11 entry off", {31'd0, dq_oe_o}, 32'd0);
    wr_cmd(3, 32'hDEAD_BEEF, 4'h0, 1); tick();
    chk("R11 asleep off", {31'd0, dq_oe_o}, 32'd0);
    tick();
    sleep = 0; tick(); tick();
    chk("R12 asleep write no flag", {31'd0, wr_err_o}, 32'd0);
    tick();
    chk("R12 recovery write flagged", {31'd0, wr_err_o}, 32'd1);
    rd_cmd(3, 0); tick();
    chk("R12 flag one cycle", {31'd0, wr_err_o}, 32'd0);
    go_idle(); tick();
    chk("R11 R12 retained data", dq_o, model[3]);
    chk("R12 read in recovery drives", {31'd0, dq_oe_o}, 32'd1);
    wr_cmd(3, 32'hCAFE_F00D, 4'h0, 1); mdl_wr(3, 32'hCAFE_F00D, 4'hF); tick();
    chk("R12 write after window", {31'd0, wr_err_o}, 32'd0);
    rd_cmd(3, 0); tick();
    go_idle(); tick();
    chk("R12 write after window data", dq_o, model[3]);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule